// File: doc/BRIEF.md
# Dual-Rate Fourth-Order Sinc Decimator

This block turns the one-bit stream of a delta-sigma modulator into signed 24-bit conversion results. Each enabled modulator bit counts as +1 (bit high) or -1 (bit low). The bits pass through four cascaded integrators running at the modulator rate and then through four comb stages running at the output rate. The combined response is a boxcar of length R convolved with itself four times, so every notch of the response carries four coincident zeros.

A rate input picks the decimation ratio. With the modulator at 76.8 kHz, the defaults give 10 results per second (ratio 7680, notches on every multiple of 10 Hz, so 50 Hz and 60 Hz are rejected together) or 80 results per second (ratio 960). The raw sum is scaled to the 24-bit two's complement range, and inputs at or beyond full scale clip to the signed limits. A settled flag tells the host which results still carry state from before a reset or a rate change and should be discarded.

Top module: `sinc4_decim`

## Requirements
- R1: Let R be the active ratio, W = 4*ceil(log2(R_SLOW or R_FAST as selected)), G = ceil(2^(W+23) / R^4), and raw = sum over j of h[j]*x[n-j]. Here h is the length-R unit boxcar convolved four times, x is +1 for a high bit and -1 for a low bit, and x is 0 for samples before the last reset or restart. Each result is then floor(raw*G / 2^W), clipped to the 24-bit signed range.
- R2: A result is produced on the clock edge that takes the R-th enabled sample since the previous result, reset or restart. R is R_SLOW when rate_fast_i is low and R_FAST when it is high. valid_o is high for exactly that one cycle.
- R3: Results clip to 7FFFFFh and 800000h. An all-high stream gives 7FFFFFh and an all-low stream gives 800000h once settled.
- R4: A strictly alternating stream gives 000000h once settled (even ratios).
- R5: settled_o is low for the first three results after a reset or restart. It rises together with the valid of the fourth result and stays high until the next reset or restart.
- R6: A change of rate_fast_i clears the integrators, the comb stages, the decimation count and the settled state on the next edge. A sample enabled in that cycle is discarded, no result is produced in that cycle, and result_o keeps its last value.
- R7: In a cycle with bit_en_i low, no result is produced and no filter state advances.
- R8: While rst_ni is low, result_o is 000000h and valid_o and settled_o are low, and the slow rate is selected.
- R9: result_o changes only on the cycle that valid_o is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bit_i | input | 1 | Modulator output bit |
| bit_en_i | input | 1 | Qualifies bit_i as one modulator sample |
| rate_fast_i | input | 1 | Low: ratio R_SLOW, high: ratio R_FAST |
| result_o | output | 24 | Two's complement conversion result |
| valid_o | output | 1 | One-cycle strobe with each new result |
| settled_o | output | 1 | Filter holds only post-restart samples |

## Verification
The assertions assume both ratios are at least two, so two results can never fall on adjacent cycles. They also assume rate_fast_i changes only between clock edges, so the comparison with the registered rate marks a restart cleanly. The bench uses a ratio of 24 and a ratio of 6, drives rate_fast_i and bit_en_i only on falling edges, and inserts idle cycles into the sample stream. This keeps every enabled bit on a single, unambiguous edge.

// File: rtl/sinc4_pkg.sv
`timescale 1ns/1ps
package sinc4_pkg;
  localparam int unsigned ORDER  = 4;
  localparam int unsigned GAIN_W = 28;

  // ceil(2^(ORDER*clog2(r)+23) / r^ORDER)
  function automatic logic [31:0] scale_gain(input int unsigned r);
    logic [127:0] den;
    logic [127:0] num;
    logic [127:0] q;
    den = 128'(r);
    den = den * den;
    den = den * den;
    num = 128'(1) << (ORDER * $clog2(r) + 23);
    q   = num / den;
    if (q * den != num) q = q + 128'(1);
    return q[31:0];
  endfunction
endpackage

// File: rtl/sinc4_integ.sv
`timescale 1ns/1ps
module sinc4_integ #(
  parameter int unsigned ACC_W = 53,
  parameter int unsigned ORDER = 4
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    clr_i,
  input  logic                    en_i,
  input  logic                    bit_i,
  output logic signed [ACC_W-1:0] sum_o
);
  logic signed [ACC_W-1:0] x;
  logic signed [ACC_W-1:0] acc_d [ORDER];

  assign x = bit_i ? ACC_W'(1) : '1;

  for (genvar s = 0; s < ORDER; s++) begin : g_stage
    logic signed [ACC_W-1:0] acc_q;
    if (s == 0) begin : g_first
      assign acc_d[s] = acc_q + x;
    end else begin : g_next
      assign acc_d[s] = acc_q + acc_d[s-1];
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)    acc_q <= '0;
      else if (clr_i) acc_q <= '0;
      else if (en_i)  acc_q <= acc_d[s];
    end
  end

  // last stage seen combinationally so the comb takes the current sample
  assign sum_o = acc_d[ORDER-1];
endmodule

// File: rtl/sinc4_comb.sv
`timescale 1ns/1ps
module sinc4_comb #(
  parameter int unsigned ACC_W = 53,
  parameter int unsigned ORDER = 4
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    clr_i,
  input  logic                    dec_i,
  input  logic signed [ACC_W-1:0] din_i,
  output logic signed [ACC_W-1:0] dout_o
);
  logic signed [ACC_W-1:0] diff [ORDER+1];

  assign diff[0] = din_i;

  for (genvar s = 0; s < ORDER; s++) begin : g_stage
    logic signed [ACC_W-1:0] dly_q;
    assign diff[s+1] = diff[s] - dly_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)    dly_q <= '0;
      else if (clr_i) dly_q <= '0;
      else if (dec_i) dly_q <= diff[s];
    end
  end

  assign dout_o = diff[ORDER];
endmodule

// File: rtl/sinc4_scale.sv
`timescale 1ns/1ps
module sinc4_scale
  import sinc4_pkg::*;
#(
  parameter int unsigned ACC_W  = 53,
  parameter int unsigned R_SLOW = 7680,
  parameter int unsigned R_FAST = 960,
  parameter int unsigned OUT_W  = 24
) (
  input  logic signed [ACC_W-1:0] raw_i,
  input  logic                    fast_i,
  output logic [OUT_W-1:0]        res_o
);
  localparam int unsigned PW  = ACC_W + GAIN_W;
  localparam int unsigned W_S = ORDER * $clog2(R_SLOW);
  localparam int unsigned W_F = ORDER * $clog2(R_FAST);
  localparam logic [GAIN_W-1:0] G_S = GAIN_W'(scale_gain(R_SLOW));
  localparam logic [GAIN_W-1:0] G_F = GAIN_W'(scale_gain(R_FAST));
  localparam logic signed [PW-1:0] HI = PW'((64'd1 << (OUT_W-1)) - 64'd1);
  localparam logic signed [PW-1:0] LO = ~HI;

  logic [GAIN_W-1:0]      gain;
  logic signed [PW-1:0]   raw_x;
  logic signed [PW-1:0]   gain_x;
  logic signed [PW-1:0]   prod;
  logic signed [PW-1:0]   shifted;

  assign gain    = fast_i ? G_F : G_S;
  assign raw_x   = PW'(raw_i);
  assign gain_x  = $signed(PW'(gain));
  assign prod    = raw_x * gain_x;
  assign shifted = fast_i ? (prod >>> W_F) : (prod >>> W_S);

  always_comb begin
    if (shifted > HI)      res_o = {1'b0, {(OUT_W-1){1'b1}}};
    else if (shifted < LO) res_o = {1'b1, {(OUT_W-1){1'b0}}};
    else                   res_o = shifted[OUT_W-1:0];
  end
endmodule

// File: rtl/sinc4_decim.sv
`timescale 1ns/1ps
module sinc4_decim
  import sinc4_pkg::*;
#(
  parameter int unsigned R_SLOW = 7680,
  parameter int unsigned R_FAST = 960,
  parameter int unsigned OUT_W  = 24
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             bit_i,
  input  logic             bit_en_i,
  input  logic             rate_fast_i,
  output logic [OUT_W-1:0] result_o,
  output logic             valid_o,
  output logic             settled_o
);
  localparam int unsigned ACC_W = ORDER * $clog2(R_SLOW) + 1;
  localparam int unsigned CNT_W = $clog2(R_SLOW);
  localparam logic [CNT_W-1:0] LAST_S = CNT_W'(R_SLOW - 1);
  localparam logic [CNT_W-1:0] LAST_F = CNT_W'(R_FAST - 1);

  logic                    rate_q;
  logic [CNT_W-1:0]        cnt_q;
  logic [1:0]              nres_q;
  logic                    settled_q;
  logic                    valid_q;
  logic [OUT_W-1:0]        res_q;
  logic                    restart;
  logic                    take;
  logic                    last;
  logic                    dec;
  logic signed [ACC_W-1:0] integ_sum;
  logic signed [ACC_W-1:0] comb_out;
  logic [OUT_W-1:0]        scaled;

  assign restart = rate_fast_i != rate_q;
  assign take    = bit_en_i && !restart;
  assign last    = cnt_q == (rate_q ? LAST_F : LAST_S);
  assign dec     = take && last;

  sinc4_integ #(.ACC_W(ACC_W), .ORDER(ORDER)) u_integ (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (restart),
    .en_i  (take),
    .bit_i (bit_i),
    .sum_o (integ_sum)
  );

  sinc4_comb #(.ACC_W(ACC_W), .ORDER(ORDER)) u_comb (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (restart),
    .dec_i (dec),
    .din_i (integ_sum),
    .dout_o(comb_out)
  );

  sinc4_scale #(.ACC_W(ACC_W), .R_SLOW(R_SLOW), .R_FAST(R_FAST), .OUT_W(OUT_W)) u_scale (
    .raw_i (comb_out),
    .fast_i(rate_q),
    .res_o (scaled)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rate_q    <= 1'b0;
      cnt_q     <= '0;
      nres_q    <= '0;
      settled_q <= 1'b0;
      valid_q   <= 1'b0;
      res_q     <= '0;
    end else begin
      valid_q <= dec;
      if (restart) begin
        rate_q    <= rate_fast_i;
        cnt_q     <= '0;
        nres_q    <= '0;
        settled_q <= 1'b0;
      end else if (take) begin
        cnt_q <= last ? '0 : cnt_q + CNT_W'(1);
        if (last) begin
          res_q <= scaled;
          if (!settled_q) begin
            if (nres_q == 2'd3) settled_q <= 1'b1;
            else                nres_q    <= nres_q + 2'd1;
          end
        end
      end
    end
  end

  assign result_o  = res_q;
  assign valid_o   = valid_q;
  assign settled_o = settled_q;
endmodule

// File: rtl/sinc4_decim_chk.sv
`timescale 1ns/1ps
module sinc4_decim_chk #(
  parameter int unsigned OUT_W = 24
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             bit_en_i,
  input logic             rate_fast_i,
  input logic             rate_q,
  input logic [OUT_W-1:0] result_o,
  input logic             valid_o,
  input logic             settled_o
);
  assert_valid_single_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);

  assert_valid_needs_en_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> $past(bit_en_i));

  assert_result_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(result_o) |-> valid_o);

  assert_settled_rise_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(settled_o) |-> valid_o);

  assert_settled_fall_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(settled_o) |-> $past(rate_fast_i != rate_q));

  assert_restart_quiet_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rate_fast_i != rate_q) |=> !valid_o);
endmodule

bind sinc4_decim sinc4_decim_chk #(.OUT_W(OUT_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .bit_en_i   (bit_en_i),
  .rate_fast_i(rate_fast_i),
  .rate_q     (rate_q),
  .result_o   (result_o),
  .valid_o    (valid_o),
  .settled_o  (settled_o)
);

// File: tb/sinc4_decim_tb.sv
`timescale 1ns/1ps
module sinc4_decim_tb;
  localparam int RS = 24;
  localparam int RF = 6;
  // {rate, pattern[2:0], results[3:0]}
  localparam logic [7:0] VEC [12] = '{
    {1'b0, 3'd0, 4'd6}, {1'b0, 3'd1, 4'd6}, {1'b0, 3'd2, 4'd5}, {1'b0, 3'd3, 4'd5},
    {1'b1, 3'd0, 4'd6}, {1'b1, 3'd4, 4'd5}, {1'b1, 3'd5, 4'd6}, {1'b1, 3'd1, 4'd6},
    {1'b0, 3'd5, 4'd6}, {1'b0, 3'd6, 4'd5}, {1'b1, 3'd2, 4'd5}, {1'b0, 3'd4, 4'd5}
  };

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        bit_i = 1'b0;
  logic        bit_en_i = 1'b0;
  logic        rate_fast_i = 1'b0;
  logic [23:0] result_o;
  logic        valid_o;
  logic        settled_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  int     hist [256];
  int     hk [256];
  int     klen;
  int     nsamp;
  int     rr;
  int     wsh;
  longint gain;
  logic [23:0] last_res;
  logic   cur_rate;
  int     k = 0;

  always #4 clk = ~clk;

  sinc4_decim #(.R_SLOW(RS), .R_FAST(RF), .OUT_W(24)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .bit_i(bit_i), .bit_en_i(bit_en_i),
    .rate_fast_i(rate_fast_i), .result_o(result_o), .valid_o(valid_o),
    .settled_o(settled_o)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic int clg(input int v);
    int r = 0;
    while ((1 << r) < v) r++;
    return r;
  endfunction

  task automatic set_model(input int r);
    int a [256];
    int b [256];
    int len;
    longint r4;
    for (int i = 0; i < 256; i++) begin a[i] = 0; hist[i] = 0; end
    a[0] = 1;
    len = 1;
    for (int st = 0; st < 4; st++) begin
      for (int i = 0; i < len + r - 1; i++) begin
        b[i] = 0;
        for (int j = 0; j < r; j++)
          if (i - j >= 0 && i - j < len) b[i] += a[i-j];
      end
      len = len + r - 1;
      for (int i = 0; i < len; i++) a[i] = b[i];
    end
    for (int i = 0; i < len; i++) hk[i] = a[i];
    klen  = len;
    rr    = r;
    nsamp = 0;
    wsh   = 4 * clg(r);
    r4    = longint'(r) * r * r * r;
    gain  = ((64'sd1 <<< (wsh + 23)) + r4 - 1) / r4;
  endtask

  function automatic logic [23:0] model_out();
    longint raw = 0;
    longint v;
    for (int j = 0; j < klen; j++)
      if (nsamp - 1 - j >= 0) raw += longint'(hk[j]) * hist[(nsamp - 1 - j) % 256];
    v = (raw * gain) >>> wsh;
    if (v > 64'sd8388607) v = 64'sd8388607;
    if (v < -64'sd8388608) v = -64'sd8388608;
    return v[23:0];
  endfunction

  function automatic bit pat(input int p, input int kk);
    case (p)
      0: return 1'b1;
      1: return 1'b0;
      2: return kk[0];
      3: return (kk % 4) != 0;
      4: return (kk % 4) == 0;
      5: return ((kk * 37 + 11) % 7) < 3;
      default: return (kk % 3) != 0;
    endcase
  endfunction

  // caller sits at a falling edge
  task automatic push(input bit b, input bit en);
    bit exp_v = 1'b0;
    logic [23:0] e;
    bit_i = b;
    bit_en_i = en;
    @(negedge clk);
    if (en) begin
      hist[nsamp % 256] = b ? 1 : -1;
      nsamp++;
      exp_v = (nsamp % rr) == 0;
    end
    chk(valid_o == exp_v, en ? "R2 valid timing" : "R7 idle no valid", valid_o, exp_v);
    if (exp_v) begin
      e = model_out();
      chk(result_o == e, "R1 filtered result", result_o, e);
      chk(settled_o == ((nsamp / rr) >= 4), "R5 settled flag", settled_o, (nsamp / rr) >= 4);
      last_res = result_o;
    end else begin
      chk(result_o == last_res, "R9 result hold", result_o, last_res);
    end
  endtask

  task automatic set_rate(input logic r, input bit en, input bit b);
    rate_fast_i = r;
    bit_en_i = en;
    bit_i = b;
    @(negedge clk);
    chk(valid_o == 1'b0, "R6 no result on restart", valid_o, 0);
    chk(settled_o == 1'b0, "R6 settled cleared", settled_o, 0);
    chk(result_o == last_res, "R6 result kept", result_o, last_res);
    set_model(r ? RF : RS);
    cur_rate = r;
  endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    bit_en_i = 1'b0;
    rate_fast_i = 1'b0;
    repeat (2) @(negedge clk);
    chk(result_o == 24'h0, "R8 reset result", result_o, 0);
    chk(valid_o == 1'b0, "R8 reset valid", valid_o, 0);
    chk(settled_o == 1'b0, "R8 reset settled", settled_o, 0);
    rst_ni = 1'b1;
    @(negedge clk);
    chk(valid_o == 1'b0 && result_o == 24'h0, "R8 after release", result_o, 0);
    set_model(RS);
    last_res = '0;
    cur_rate = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    do_reset();

    for (int i = 0; i < 12; i++) begin
      logic [7:0] v;
      int target;
      v = VEC[i];
      if (v[7] != cur_rate) set_rate(v[7], 1'b0, 1'b0);
      target = nsamp / rr + int'(v[3:0]);
      while (nsamp / rr < target) begin
        k++;
        push(pat(int'(v[6:4]), k), (k % 7) != 0);
      end
    end

    // R3 clip at both limits
    do_reset();
    for (int i = 0; i < 5 * RS; i++) push(1'b1, 1'b1);
    chk(last_res == 24'h7FFFFF, "R3 positive clip", last_res, 24'h7FFFFF);
    chk(settled_o == 1'b1, "R5 settled after fifth", settled_o, 1);
    set_rate(1'b1, 1'b0, 1'b0);
    for (int i = 0; i < 5 * RF; i++) push(1'b0, 1'b1);
    chk(last_res == 24'h800000, "R3 negative clip", last_res, 24'h800000);

    // R4 alternating stream
    for (int i = 0; i < 5 * RF; i++) push(i[0], 1'b1);
    chk(last_res == 24'h000000, "R4 balanced zero", last_res, 0);

    // R8 reset mid-conversion, count restarts from zero
    for (int i = 0; i < 3; i++) push(1'b1, 1'b1);
    do_reset();
    for (int i = 0; i < RS; i++) push(1'b1, 1'b1);

    // R6 rate change with a sample offered in that cycle
    for (int i = 0; i < 9; i++) push(1'b1, 1'b1);
    set_rate(1'b1, 1'b1, 1'b1);
    for (int i = 0; i < RF - 1; i++) push(1'b1, 1'b1);
    chk(valid_o == 1'b0, "R6 dropped sample not counted", valid_o, 0);
    for (int i = 0; i < 4 * RF; i++) push(1'b1, 1'b1);
    chk(settled_o == 1'b1, "R6 settles on fourth", settled_o, 1);

    // R7 idle cycles leave everything in place
    for (int i = 0; i < 20; i++) push(1'b0, 1'b0);
    chk(result_o == last_res && settled_o == 1'b1, "R7 idle state kept", result_o, last_res);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule